// File: doc/BRIEF.md
# Clock Gate Controller with Hardware/Software Arbitration and Turn-off Hysteresis

This block owns the control register of one gated clock and produces the enable that drives an external clock gating cell. One register bit chooses the controlling source: a hardware request input, or a software enable bit held in the register. The gate turns on one cycle after its request rises. When the request falls, the gate either turns off one cycle later or keeps running for a programmable short or long delay. A request that returns during that delay cancels the pending turn-off.

A read-only status bit reports the actual gate state. It passes through a two-stage synchronizer, so it lags the gate enable, and software polls it until it matches what was asked for. A build-time option marks the gate as one that must never stop while software controls it: a 0 in the enable bit then leaves the clock running.

Top module: `ckg_gate`

## Requirements
- R1: After reset the gate enable and the status are 0 and every register field reads 0, which selects hardware control with hysteresis off.
- R2: The register holds the software enable in bit 0, the source select in bit 1 (1 = software, 0 = hardware), the hysteresis enable in bit 2 and the long-delay select in bit 3 (1 = long, 0 = short); bit 4 reads the status, and writes to bit 4 are ignored.
- R3: Under software control the gate enable follows the enable bit and rises on the first clock edge after the edge that wrote the register.
- R4: Under hardware control the gate enable rises on the first clock edge that samples the hardware request high, and the software enable bit has no effect on it.
- R5: When the gate is built as no-disable and software control is selected, the gate runs with the enable bit 0.
- R6: With hysteresis off, the gate enable falls on the first clock edge that samples the request low.
- R7: With hysteresis on and the short delay selected, the gate enable falls LOW_DLY cycles later than it would with hysteresis off.
- R8: With hysteresis on and the long delay selected, the gate enable falls HIGH_DLY cycles later than it would with hysteresis off.
- R9: A request that returns during the turn-off delay keeps the gate running, and the next turn-off waits the full delay again.
- R10: The status output and register bit 4 equal the gate enable of two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 5 | Register write data |
| rd_data_o | output | 5 | Register read data, status in bit 4 |
| hw_req_i | input | 1 | Hardware clock request |
| gate_en_o | output | 1 | Enable to the clock gating cell |
| status_o | output | 1 | Synchronized gate state |

## Verification
The hardest state to reach is a turn-off delay interrupted part way: the request must drop, the bench must wait fewer cycles than the delay while confirming the gate still runs, and then bring the request back before the counter expires. The bench does this under software control, then drops the request once more and times the second turn-off, which shows the counter restarted rather than resumed. All eight combinations of source, hysteresis enable and delay select are swept, each turn-off latency measured in cycles and compared against the delay computed from the parameters.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned F_STAT = 4;

  typedef struct packed {
    logic long_dly;   // bit 3
    logic hyst_on;    // bit 2
    logic sw_sel;     // bit 1
    logic sw_en;      // bit 0
  } ckg_ctl_t;
endpackage

// File: rtl/ckg_ctl_reg.sv
module ckg_ctl_reg
  import ckg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output ckg_ctl_t         ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctl_o <= '0;
    else if (wr_en_i) ctl_o <= ckg_ctl_t'(wr_data_i[F_STAT-1:0]);
  end

  a_r1_reset_hw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctl_o));
endmodule

// File: rtl/ckg_hyst.sv
module ckg_hyst #(
  parameter int unsigned LOW_DLY  = 16,
  parameter int unsigned HIGH_DLY = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hyst_on_i,
  input  logic long_i,
  output logic gate_o
);
  localparam int unsigned CNT_W = $clog2(HIGH_DLY + 1);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_DLY);
  localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_DLY);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dly;

  assign dly = long_i ? HIGH_C : LOW_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_o <= 1'b0;
      cnt_q  <= '0;
    end else if (req_i) begin
      gate_o <= 1'b1;
      cnt_q  <= '0;
    end else if (gate_o) begin
      if (!hyst_on_i || cnt_q >= dly) begin
        gate_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r3_on_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> gate_o);
  a_r6_off_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !hyst_on_i) |=> !gate_o);
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HIGH_C);
  a_r9_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (cnt_q == '0));
endmodule

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

  a_r10_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(d_i, STAGES) |-> q_o);
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate
  import ckg_pkg::*;
#(
  parameter int unsigned LOW_DLY    = 16,
  parameter int unsigned HIGH_DLY   = 64,
  parameter bit          NO_DISABLE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             hw_req_i,
  output logic             gate_en_o,
  output logic             status_o
);
  ckg_ctl_t ctl;
  logic     req;

  ckg_ctl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctl_o     (ctl)
  );

  // software path; a no-disable gate ignores a 0 in the enable bit
  assign req = ctl.sw_sel ? (ctl.sw_en | NO_DISABLE) : hw_req_i;

  ckg_hyst #(.LOW_DLY(LOW_DLY), .HIGH_DLY(HIGH_DLY)) u_hyst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .hyst_on_i (ctl.hyst_on),
    .long_i    (ctl.long_dly),
    .gate_o    (gate_en_o)
  );

  ckg_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gate_en_o),
    .q_o    (status_o)
  );

  assign rd_data_o = {status_o, ctl};

  a_r4_hw_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl.sw_sel && hw_req_i) |=> gate_en_o);
  a_r2_stat_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[F_STAT] == status_o);

  generate
    if (NO_DISABLE) begin : g_nodis
      a_r5_no_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl.sw_sel |=> gate_en_o);
    end
  endgenerate
endmodule

// File: tb/sim_ckg_gate.sv
module sim_ckg_gate;
  localparam int unsigned LOW  = 16;
  localparam int unsigned HIGH = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] wr_data_i = '0;
  logic       hw_req_i = 1'b0;
  logic [4:0] rd0, rd1;
  logic       gate0, gate1, stat0, stat1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  ckg_gate #(.LOW_DLY(LOW), .HIGH_DLY(HIGH), .NO_DISABLE(1'b0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd0), .hw_req_i(hw_req_i), .gate_en_o(gate0), .status_o(stat0));

  ckg_gate #(.LOW_DLY(LOW), .HIGH_DLY(HIGH), .NO_DISABLE(1'b1)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd1), .hw_req_i(hw_req_i), .gate_en_o(gate1), .status_o(stat1));

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic off_latency(output int n);
    n = 0;
    while (gate0 && n < 300) begin
      tick();
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    int exp;
    tick(3);
    // R1 reset state
    chk("R1 gate", gate0, 0);
    chk("R1 status", stat0, 0);
    chk("R1 rd", rd0, 0);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 gate after release", gate0, 0);

    // R2 field readback, status bit not writable
    wr(5'b1_1100);
    chk("R2 readback", rd0, 5'b0_1100);
    wr(5'b0_0000);

    // R4 software enable bit ignored under hardware control
    wr(5'b0_0001);
    tick(4);
    chk("R4 sw_en ignored", gate0, 0);
    chk("R4 sw_en ignored status", rd0[4], 0);

    // R3 software turn-on latency and R10 status lag
    wr(5'b0_0011);
    chk("R3 before edge", gate0, 0);
    tick();
    chk("R3 on", gate0, 1);
    chk("R10 lag1", stat0, 0);
    tick();
    chk("R10 lag2", stat0, 0);
    tick();
    chk("R10 status", stat0, 1);
    chk("R10 rd bit4", rd0[4], 1);
    wr(5'b0_0010);
    off_latency(n);
    chk("R6 sw off", n, 1);
    chk("R10 status lag off", stat0, 1);
    tick(2);
    chk("R10 status off", stat0, 0);

    // sweep source x hysteresis enable x delay select
    for (int src = 0; src < 2; src++) begin
      for (int hen = 0; hen < 2; hen++) begin
        for (int hhi = 0; hhi < 2; hhi++) begin
          logic [4:0] cfg;
          cfg = {1'b0, hhi[0], hen[0], src[0], 1'b0};
          exp = 1 + (hen != 0 ? (hhi != 0 ? HIGH : LOW) : 0);
          if (src != 0) begin
            wr(cfg | 5'b0_0001);
            tick();
            chk("R3 sweep on", gate0, 1);
            tick(3);
            wr(cfg);
          end else begin
            wr(cfg);
            hw_req_i = 1'b1;
            tick();
            chk("R4 sweep on", gate0, 1);
            tick(3);
            hw_req_i = 1'b0;
          end
          off_latency(n);
          if (hen == 0)      chk("R6 off latency", n, exp);
          else if (hhi == 0) chk("R7 short delay", n, exp);
          else               chk("R8 long delay", n, exp);
          tick(3);
        end
      end
    end

    // R9 cancel during the short delay, then full delay again
    wr(5'b0_0111);
    tick(2);
    wr(5'b0_0110);
    tick(LOW / 2);
    chk("R9 still running", gate0, 1);
    wr(5'b0_0111);
    tick(LOW + 4);
    chk("R9 held on", gate0, 1);
    wr(5'b0_0110);
    off_latency(n);
    chk("R9 full delay", n, 1 + LOW);

    // R5 no-disable gate under software control with enable 0
    wr(5'b0_0010);
    tick(2);
    chk("R5 no-disable runs", gate1, 1);
    chk("R5 normal gate off", gate0, 0);
    tick(4);
    chk("R5 status", stat1, 1);
    wr(5'b0_0000);
    tick(2);
    chk("R5 hw control releases", gate1, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule